// File: doc/BRIEF.md
# AES3 channel status bit generator

This block supplies the channel status (C), validity (V) and user (U) bits that an AES3 or S/PDIF transmitter places in each outgoing subframe, and it keeps track of where the channel status block begins and ends. It runs on a fast master clock. The serial audio left/right clock is synchronised into that domain, and each of its edges starts a new subframe. On that subframe boundary the block emits one strobe together with the three bits for the subframe. A downstream encoder latches these bits into its biphase-mark stream.

Channel status comes from one of two sources. In fixed-pin mode, four static pins build a consumer-format block: audio/non-audio, copy permission, pre-emphasis and generation status. In streamed mode, a single input carries the C bit serially and is sampled once per subframe. A block-start pin set has a direction select. Used as an output, it marks the first subframe of every block. Used as an input, a pulse of at least a minimum width in master clocks forces the next subframe to restart the block. Shorter pulses are rejected.

Top module: `aes_cs_bitgen`

## Requirements
- R1: The subframe index advances by one on every left/right clock edge and wraps from 2*FRAMES-1 to 0. The first subframe after reset has index 0. `sf_first` is 1 exactly when the current subframe index is 0.
- R2: Every left/right clock edge produces exactly one single-cycle `sf_stb` pulse. The pulse appears on the third rising master clock edge after the input edge. All subframe outputs update with that pulse. `sf_chan` equals the new left/right clock level. After reset, `sf_stb`, `sf_first`, `sf_c` and `blk_o` are 0.
- R3: In both modes, `sf_v` and `sf_u` take the values of `v_in` and `u_in` present when the subframe boundary is registered.
- R4: With `cmode`=1 (streamed), `sf_c` takes the value of `c_in` present at the subframe boundary.
- R5: With `cmode`=0 (fixed), channel status bit 0 (professional) is 0. Every bit other than 1, 2, 3 and 15 is 0. The bit number is the subframe index divided by two, so the left and right subframes of a frame carry the same bit.
- R6: With `cmode`=0, bits 3, 4 and 5 are 1, 0, 0 when `pin_emph`=0 (50/15 us pre-emphasis) and 0, 0, 0 when `pin_emph`=1.
- R7: With `cmode`=0, bit 1 equals the inverse of `pin_audio`, so a high pin marks linear PCM audio.
- R8: With `cmode`=0, bit 2 (copy permitted) equals `pin_copy` and bit 15 (generation status) equals `pin_orig`.
- R9: With `blk_dir`=1, `blk_oe` is 1 and `blk_o` follows `sf_first`. With `blk_dir`=0, both are 0.
- R10: With `blk_dir`=0, a `blk_i` high for at least MINW master clocks (counted after a two-flop synchroniser) makes the next subframe index 0.
- R11: A `blk_i` pulse shorter than MINW clocks, or any `blk_i` activity while `blk_dir`=1, leaves the subframe sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lrclk | input | 1 | Serial audio left/right clock; each edge is a subframe boundary |
| cmode | input | 1 | 0 = fixed-pin channel status, 1 = streamed C bit |
| pin_copy | input | 1 | Fixed mode: copy permitted |
| pin_orig | input | 1 | Fixed mode: generation status bit |
| pin_emph | input | 1 | Fixed mode: 0 = 50/15 us pre-emphasis, 1 = none |
| pin_audio | input | 1 | Fixed mode: 1 = linear PCM audio, 0 = non-audio |
| v_in | input | 1 | Validity bit for the next subframe |
| u_in | input | 1 | User bit for the next subframe |
| c_in | input | 1 | Streamed mode channel status bit |
| blk_dir | input | 1 | Block-start direction: 1 = output, 0 = input |
| blk_i | input | 1 | Block-start request input |
| blk_o | output | 1 | Block-start marker output |
| blk_oe | output | 1 | Block-start output enable |
| sf_stb | output | 1 | One-cycle pulse at each new subframe |
| sf_chan | output | 1 | Left/right clock level of the current subframe |
| sf_first | output | 1 | Current subframe is the first of a block |
| sf_c | output | 1 | Channel status bit of the current subframe |
| sf_v | output | 1 | Validity bit of the current subframe |
| sf_u | output | 1 | User bit of the current subframe |

## Verification
The bench builds the block with FRAMES=24 and MINW=3. A 48-subframe block wraps many times within a short run. The bench can still see every fixed-mode bit position that carries a value, including bit 15, and the zero bits on both sides of it. MINW=3 puts the accept and reject widths of the block-start input one clock apart, so a two-clock pulse, a three-clock pulse and pulses given while the pin drives out can each be placed at chosen points within the block.

// File: rtl/aes_cs_bitgen.sv
module aes_cs_bitgen #(
  parameter int FRAMES = 192,
  parameter int MINW   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lrclk,
  input  logic cmode,
  input  logic pin_copy,
  input  logic pin_orig,
  input  logic pin_emph,
  input  logic pin_audio,
  input  logic v_in,
  input  logic u_in,
  input  logic c_in,
  input  logic blk_dir,
  input  logic blk_i,
  output logic blk_o,
  output logic blk_oe,
  output logic sf_stb,
  output logic sf_chan,
  output logic sf_first,
  output logic sf_c,
  output logic sf_v,
  output logic sf_u
);
  localparam int SUBS = 2 * FRAMES;
  localparam int IW   = $clog2(SUBS);
  localparam int CW   = $clog2(MINW + 1);
  localparam logic [IW-1:0] LAST = IW'(SUBS - 1);

  logic [2:0]    lr_s;
  logic [1:0]    b_s;
  logic [CW-1:0] wcnt;
  logic          pend, arm, sub_edge, fixed_c;
  logic [IW-1:0] sf_idx, idx_nx;
  logic [IW-2:0] bitn;

  assign sub_edge = lr_s[2] ^ lr_s[1];
  assign idx_nx   = pend ? '0 : (sf_idx == LAST ? '0 : sf_idx + IW'(1));
  assign bitn     = idx_nx[IW-1:1];

  always_comb begin
    fixed_c = 1'b0;
    if (bitn == (IW-1)'(1))  fixed_c = ~pin_audio;
    if (bitn == (IW-1)'(2))  fixed_c = pin_copy;
    if (bitn == (IW-1)'(3))  fixed_c = ~pin_emph;
    if (bitn == (IW-1)'(15)) fixed_c = pin_orig;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_s     <= '0;
      sf_idx   <= LAST;
      sf_stb   <= 1'b0;
      sf_chan  <= 1'b0;
      sf_first <= 1'b0;
      sf_c     <= 1'b0;
      sf_v     <= 1'b0;
      sf_u     <= 1'b0;
    end else begin
      lr_s   <= {lr_s[1:0], lrclk};
      sf_stb <= sub_edge;
      if (sub_edge) begin
        sf_idx   <= idx_nx;
        sf_first <= (idx_nx == '0);
        sf_chan  <= lr_s[1];
        sf_c     <= cmode ? c_in : fixed_c;
        sf_v     <= v_in;
        sf_u     <= u_in;
      end
    end
  end

  assign arm = !blk_dir && b_s[1] && (wcnt == CW'(MINW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_s  <= '0;
      wcnt <= '0;
      pend <= 1'b0;
    end else begin
      b_s <= {b_s[0], blk_i};
      if (blk_dir || !b_s[1]) wcnt <= '0;
      else if (wcnt != CW'(MINW)) wcnt <= wcnt + CW'(1);
      pend <= arm | (pend & ~sub_edge);
    end
  end

  assign blk_oe = blk_dir;
  assign blk_o  = blk_dir & sf_first;

  p_idx_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sf_idx <= LAST);
  p_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sub_edge && !pend && sf_idx != LAST |=> sf_idx == $past(sf_idx) + IW'(1));
  p_stb_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_edge |=> $stable(sf_c) && $stable(sf_v) && $stable(sf_u) && $stable(sf_chan));
  p_pro_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sub_edge && !cmode && !pend && sf_idx == LAST |=> !sf_c);
  p_dir_in_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_dir |-> !blk_o && !blk_oe);
  p_resync_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sub_edge && pend |=> sf_first);
  p_no_arm_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
    blk_dir && !pend |=> !pend || $past(!blk_dir));
endmodule

// File: tb/aes_cs_bitgen_bench.sv
module aes_cs_bitgen_bench;
  localparam int FRAMES = 24;
  localparam int MINW   = 3;
  localparam int SUBS   = 2 * FRAMES;

  logic clk = 0, rst_n = 0;
  logic lrclk = 0, cmode = 0, pin_copy = 0, pin_orig = 0, pin_emph = 1, pin_audio = 1;
  logic v_in = 0, u_in = 0, c_in = 0, blk_dir = 1, blk_i = 0;
  logic blk_o, blk_oe, sf_stb, sf_chan, sf_first, sf_c, sf_v, sf_u;

  int checks = 0, fails = 0, exp_idx = SUBS - 1;
  bit done = 0;

  always #5 clk = ~clk;

  aes_cs_bitgen #(.FRAMES(FRAMES), .MINW(MINW)) u_aes_cs_bitgen (
    .clk, .rst_n, .lrclk, .cmode, .pin_copy, .pin_orig, .pin_emph, .pin_audio,
    .v_in, .u_in, .c_in, .blk_dir, .blk_i, .blk_o, .blk_oe,
    .sf_stb, .sf_chan, .sf_first, .sf_c, .sf_v, .sf_u);

  function automatic logic fix_bit(int b, logic au, logic cp, logic em, logic org);
    case (b)
      1: return ~au;
      2: return cp;
      3: return ~em;
      15: return org;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (idx %0d)", tag, act, exp, exp_idx);
    end
  endtask

  task automatic subframe(bit resync);
    int stbs = 0;
    logic ec;
    @(negedge clk);
    v_in = 1'($urandom); u_in = 1'($urandom); c_in = 1'($urandom);
    lrclk = ~lrclk;
    exp_idx = resync ? 0 : (exp_idx == SUBS - 1 ? 0 : exp_idx + 1);
    ec = cmode ? c_in : fix_bit(exp_idx / 2, pin_audio, pin_copy, pin_emph, pin_orig);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (sf_stb) stbs++;
    end
    check("R2 stb count", stbs, 1);
    check("R2 chan", sf_chan, lrclk);
    check("R1 first", sf_first, exp_idx == 0);
    check("R3 v", sf_v, v_in);
    check("R3 u", sf_u, u_in);
    if (cmode) check("R4 c stream", sf_c, ec);
    else if (exp_idx / 2 == 0) check("R5 pro bit", sf_c, ec);
    else if (exp_idx / 2 >= 3 && exp_idx / 2 <= 5) check("R6 emph", sf_c, ec);
    else if (exp_idx / 2 == 1) check("R7 audio", sf_c, ec);
    else if (exp_idx / 2 == 2 || exp_idx / 2 == 15) check("R8 copy/orig", sf_c, ec);
    else check("R5 zero bit", sf_c, ec);
    check("R9 blk_o", blk_o, blk_dir & (exp_idx == 0));
    check("R9 blk_oe", blk_oe, blk_dir);
  endtask

  task automatic pulse(int len);
    @(negedge clk);
    blk_i = 1;
    repeat (len) @(negedge clk);
    blk_i = 0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R2 reset stb", sf_stb, 0);
    check("R2 reset first", sf_first, 0);
    check("R2 reset c", sf_c, 0);
    check("R2 reset blk_o", blk_o, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    for (int n = 0; n < 240; n++) begin
      if (n % 7 == 0) begin
        cmode = 1'($urandom); pin_copy = 1'($urandom); pin_orig = 1'($urandom);
        pin_emph = 1'($urandom); pin_audio = 1'($urandom); blk_dir = 1'($urandom);
      end
      subframe(0);
    end
    cmode = 0; pin_emph = 0; pin_audio = 0; pin_copy = 1; pin_orig = 1;
    for (int n = 0; n < SUBS; n++) subframe(0);
    pin_emph = 1; pin_audio = 1; pin_copy = 0; pin_orig = 0;
    for (int n = 0; n < SUBS; n++) subframe(0);
    blk_dir = 0;
    for (int n = 0; n < 5; n++) subframe(0);
    pulse(MINW);
    subframe(1);
    check("R10 resync first", sf_first, 1);
    for (int n = 0; n < 9; n++) subframe(0);
    pulse(MINW - 1);
    subframe(0);
    check("R11 short pulse", sf_first, exp_idx == 0);
    pulse(MINW + 4);
    subframe(1);
    check("R10 long pulse", sf_first, 1);
    for (int n = 0; n < 6; n++) subframe(0);
    blk_dir = 1;
    pulse(MINW + 3);
    subframe(0);
    check("R11 pulse while output", sf_first, 0);
    for (int n = 0; n < 60; n++) begin
      if (n % 11 == 3) begin
        blk_dir = 0; pulse(MINW + 32'($urandom % 3)); subframe(1);
      end else subframe(0);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule